// File: doc/BRIEF.md
# Platform Reset Command Port

This block is a one-byte I/O register through which software asks for a platform reset. It watches an I/O bus for accesses at a single fixed port address. A write that carries the reset command bit sends a one-clock request pulse to the system reset logic. Any other write to the port keeps only the reset-type flag. Reads at the port return the byte held in the register.

The block does not sequence the reset itself. A downstream reset controller takes the request pulse and can read the reset-type flag through the normal read path to decide what kind of reset to carry out.

Top module: `sys_reset_port`

## Requirements
- R1: The block responds only when the I/O address equals PORT_ADDR, which defaults to 16'h0CF9. A read or write at any other address leaves the stored byte and the request output unchanged.
- R2: A write to the port whose data has bit 2 set drives req_o high for exactly one clock, in the cycle after the write strobe is sampled.
- R3: A write to the port with bit 2 set leaves the stored byte unchanged.
- R4: A write to the port with bit 2 clear stores data bit 1 in bit 1 and makes every other stored bit 0.
- R5: While the read strobe is high and the address matches, rd_data_o equals the stored byte. It is combinational and reflects the register in the same cycle.
- R6: rd_data_o is 0 whenever the port is not being read.
- R7: After reset the stored byte is 0 and req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O port address |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data |
| req_o | output | 1 | System reset request pulse |

## Verification
The assertions assume that the read and write strobes are plain per-cycle levels. A strobe held high for several cycles counts as that many accesses, so a write held high with bit 2 set asks for a reset on every cycle. For that reason the one-clock pulse check tests that the request follows exactly one sampled write; it does not assume the pulse is isolated. The random stimulus never raises both strobes together. It aims about half of its accesses at the port and sets the command bit at random, so stores, triggered writes and off-port accesses all mix.

// File: rtl/sys_reset_port.sv
module sys_reset_port #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0CF9,
  parameter int          DATA_W    = 8,
  parameter int          CMD_BIT   = 2,
  parameter int          TYPE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              req_o
);

  logic              hit;
  logic              wr_hit;
  logic              fire;
  logic [DATA_W-1:0] ctrl_q;

  assign hit    = (io_addr_i == ADDR_W'(PORT_ADDR));
  assign wr_hit = wr_en_i && hit;
  assign fire   = wr_hit && wr_data_i[CMD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      req_o  <= 1'b0;
    end else begin
      req_o <= fire;
      if (wr_hit && !wr_data_i[CMD_BIT]) begin
        ctrl_q           <= '0;
        ctrl_q[TYPE_BIT] <= wr_data_i[TYPE_BIT];
      end
    end
  end

  assign rd_data_o = (rd_en_i && hit) ? ctrl_q : '0;

  assert_pulse_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && io_addr_i == ADDR_W'(PORT_ADDR) && wr_data_i[CMD_BIT]) |=> req_o);

  assert_no_req_without_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && io_addr_i == ADDR_W'(PORT_ADDR) && wr_data_i[CMD_BIT]) |=> !req_o);

  assert_cmd_keeps_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[CMD_BIT]) |=> $stable(ctrl_q));

  assert_off_port_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr_i != ADDR_W'(PORT_ADDR)) |=> ($stable(ctrl_q) && !req_o));

  assert_only_type_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_q) <= 1 && (ctrl_q[TYPE_BIT] || ctrl_q == '0));

  assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> rd_data_o == '0);

endmodule

// File: tb/tb_sys_reset_port.sv
module tb_sys_reset_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr_i = 0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [7:0]  wr_data_i = 0;
  logic [7:0]  rd_data_o;
  logic        req_o;

  int checks = 0, fails = 0;
  logic [7:0] model = 0;
  localparam logic [15:0] PORT = 16'h0CF9;

  sys_reset_port dut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] next_val(logic [7:0] cur, logic [15:0] a, logic [7:0] d);
    if (a != PORT || d[2]) return cur;
    return {6'b0, d[1], 1'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a write, then check req_o one cycle later
  task automatic do_wr(logic [15:0] a, logic [7:0] d, string req);
    @(negedge clk);
    io_addr_i = a; wr_data_i = d; wr_en_i = 1;
    @(negedge clk);
    wr_en_i = 0; io_addr_i = 16'h0080;
    chk(req, {7'b0, req_o}, {7'b0, (a == PORT && d[2])});
    model = next_val(model, a, d);
    @(negedge clk);
    chk(req, {7'b0, req_o}, 8'h00);
  endtask

  task automatic do_rd(logic [15:0] a, string req);
    @(negedge clk);
    io_addr_i = a; rd_en_i = 1;
    #1;
    chk(req, rd_data_o, (a == PORT) ? model : 8'h00);
    rd_en_i = 0;
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R7", {7'b0, req_o}, 8'h00);
    rst_n = 1;
    do_rd(PORT, "R7");
    do_wr(PORT, 8'hFB, "R4");
    do_rd(PORT, "R4");
    do_wr(PORT, 8'h04, "R2");
    do_rd(PORT, "R3");
    do_wr(PORT, 8'hFF, "R3");
    do_rd(PORT, "R3");
    do_wr(16'h0CF8, 8'h00, "R1");
    do_rd(PORT, "R1");
    do_wr(16'h1CF9, 8'h04, "R1");
    do_rd(16'h0CF8, "R6");
    do_wr(PORT, 8'h00, "R4");
    do_rd(PORT, "R5");
    @(negedge clk);
    io_addr_i = PORT; #1;
    chk("R6", rd_data_o, 8'h00);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? PORT : 16'($urandom);
      if ($urandom % 2) do_wr(a, 8'($urandom), "R2");
      else do_rd(a, "R5");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule